// File: doc/BRIEF.md
# Flash Write Cycle Generator

This block turns a short stream of address/data beats into timed write cycles on an asynchronous parallel flash bus, one write cycle per beat. Each cycle drives chip enable and the address first, pulses write enable low for a programmed number of clocks, keeps the data bus driven for a hold window after the strobe rises, and then leaves the strobe high for a minimum gap. All setup, pulse, hold, gap and recovery limits are fixed cycle counts chosen as parameters from the clock period.

Commands are sent as beats on a valid/ready request port. The beat flagged as last closes the command. If that beat also carries the poll flag, the block waits out a recovery time and then reads the status word repeatedly at the last written address. It ignores samples taken inside a blanking window after the final write, because the ready bit can still read as set there. It finishes when the ready bit reads set on two accepted samples in a row, or after a maximum number of accepted samples. A single response beat reports whether polling ran, whether it timed out, and whether the last accepted status word showed an error. The request side stalls (ready low) for the whole command and until the response has been taken. The response is held until the host takes it, so back-pressure on the response port stalls the block with no loss.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset is released, request ready stays low and write enable stays high for exactly GUARD_CYC cycles; in reset all strobes are high, the data-bus enable is low and no response is offered.
- R2: For each beat, chip enable is low and the address and data are driven for SETUP_CYC cycles before write enable falls. Write enable then stays low for exactly PULSE_CYC cycles, with address, data and chip enable unchanged and chip enable low throughout.
- R3: For HOLD_CYC cycles after write enable rises, chip enable, address, data and the data-bus enable are held. Write enable then stays high for at least HOLD_CYC+GAP_CYC+SETUP_CYC cycles before it falls again.
- R4: The data-bus enable is high only while write enable is low or within HOLD_CYC cycles after it rises, and never while output enable is low.
- R5: Beats are accepted one at a time only while idle, and they are written to the bus in the order they were accepted, with their own address and data.
- R6: A last beat without the poll flag produces a response with polled=0, timeout=0 and error=0, and no status read is performed.
- R7: With polling, output enable first falls exactly HOLD_CYC+GAP_CYC+REC_CYC cycles after the final write enable rise, with the data-bus enable low.
- R8: Each status read holds chip enable and output enable low for exactly READ_CYC cycles at the last written address. The status word is sampled in the final cycle, and output enable then goes high for one cycle before the next read.
- R9: A sample is ignored when it is taken less than BLANK_CYC cycles after the final write enable rise (blank counter loaded at that edge and not yet expired).
- R10: Polling completes without timeout when bit 7 of the status word reads 1 on two consecutive accepted samples; a 0 restarts the pair.
- R11: Polling completes with timeout=1 when MAX_POLLS accepted samples pass without completion.
- R12: The error flag is 1 when the final accepted status word has any of bits 1, 3, 4 or 5 set; bits 0, 2 and 6 do not affect it.
- R13: The response stays valid with unchanged fields until rsp_ready is high, and request ready stays low while it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Request beat accepted when high with req_valid |
| req_addr | input | AW | Flash word address of the beat |
| req_data | input | DW | Data word of the beat |
| req_last | input | 1 | Beat closes the command |
| req_poll | input | 1 | Poll status after the command (read with the last beat) |
| rsp_valid | output | 1 | Command result offered |
| rsp_ready | input | 1 | Host takes the result |
| rsp_polled | output | 1 | Status polling was performed |
| rsp_timeout | output | 1 | Polling gave up after MAX_POLLS samples |
| rsp_error | output | 1 | Final status word had an error bit set |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for the data bus |
| fl_dq_in | input | DW | Data returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
A phase counter or state decode that slips by one shows at once as a write pulse, setup lead or read window one cycle off, and the bench measures these widths on every cycle of every command. A data-bus enable left on into a read would drive the bus against the flash, and it shows in the first cycle of output enable. Faults in the poll evaluator show only at the response, a few read windows later, as a wrong read count, a wrong timeout or a wrong error flag. The bench replays status scripts whose ready and error bits land on accepted and ignored samples.

// File: rtl/fwcg_pkg.sv
package fwcg_pkg;

  typedef enum logic [3:0] {
    ST_GUARD,
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_GAP,
    ST_REC,
    ST_READ,
    ST_RHIGH,
    ST_RESP
  } fwcg_state_e;

  // status word layout
  localparam int          STS_READY_BIT = 7;
  localparam logic [15:0] STS_ERR_MASK  = 16'h003A;

  function automatic int fwcg_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fwcg_timer.sv
module fwcg_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= W'(RST_VAL);
    else if (load)        cnt_q <= val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/fwcg_poll.sv
module fwcg_poll
  import fwcg_pkg::*;
#(
  parameter int DW        = 16,
  parameter int BLANK_CYC = 36,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          sample,
  input  logic [DW-1:0] word,
  output logic          fin,
  output logic          fin_to,
  output logic          fin_err
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int NW = $clog2(MAX_POLLS + 1);

  logic          blank_zero;
  logic          accept, ready_now, to_now, err_now;
  logic          run_q, fin_q, to_q, err_q;
  logic [NW-1:0] npolls_q;

  fwcg_timer #(.W(BW), .RST_VAL(0)) u_blank (
    .clk  (clk),
    .rst_n(rst_n),
    .load (arm),
    .val  (BW'(BLANK_CYC)),
    .zero (blank_zero)
  );

  assign accept    = sample && blank_zero;
  assign err_now   = (word & DW'(STS_ERR_MASK)) != '0;
  assign ready_now = accept && word[STS_READY_BIT] && run_q;
  assign to_now    = accept && !ready_now && (npolls_q == NW'(MAX_POLLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      fin_q    <= 1'b0;
      to_q     <= 1'b0;
      err_q    <= 1'b0;
      npolls_q <= '0;
    end else if (arm) begin
      run_q    <= 1'b0;
      fin_q    <= 1'b0;
      to_q     <= 1'b0;
      err_q    <= 1'b0;
      npolls_q <= '0;
    end else begin
      fin_q <= ready_now || to_now;
      if (accept) begin
        run_q    <= word[STS_READY_BIT];
        npolls_q <= npolls_q + 1'b1;
        err_q    <= err_now;
      end
      if (ready_now || to_now) to_q <= to_now;
    end
  end

  assign fin     = fin_q;
  assign fin_to  = to_q;
  assign fin_err = err_q;

  // R11
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npolls_q <= NW'(MAX_POLLS));

  // R9
  blank_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !blank_zero && !arm) |=> !fin_q);

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import fwcg_pkg::*;
#(
  parameter int AW        = 22,
  parameter int DW        = 16,
  parameter int GUARD_CYC = 38,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 15,
  parameter int HOLD_CYC  = 1,
  parameter int GAP_CYC   = 8,
  parameter int REC_CYC   = 8,
  parameter int READ_CYC  = 23,
  parameter int BLANK_CYC = 36,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_last,
  input  logic          req_poll,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_polled,
  output logic          rsp_timeout,
  output logic          rsp_error,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int MAXC = fwcg_max(fwcg_max(fwcg_max(GUARD_CYC, SETUP_CYC),
                                          fwcg_max(PULSE_CYC, HOLD_CYC)),
                                 fwcg_max(fwcg_max(GAP_CYC, REC_CYC), READ_CYC));
  localparam int PW   = $clog2(MAXC + 1);

  fwcg_state_e   st_q, st_d;
  logic          ph_load, ph_zero, arm, smp, take;
  logic [PW-1:0] ph_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          last_q, poll_q;
  logic          we_n_q, ce_n_q, oe_n_q, dqoe_q;
  logic          fin, fin_to, fin_err;

  fwcg_timer #(.W(PW), .RST_VAL(GUARD_CYC - 1)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ph_load),
    .val  (ph_val),
    .zero (ph_zero)
  );

  fwcg_poll #(.DW(DW), .BLANK_CYC(BLANK_CYC), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .sample (smp),
    .word   (fl_dq_in),
    .fin    (fin),
    .fin_to (fin_to),
    .fin_err(fin_err)
  );

  always_comb begin
    st_d    = st_q;
    ph_load = 1'b0;
    ph_val  = '0;
    arm     = 1'b0;
    smp     = 1'b0;
    take    = 1'b0;
    case (st_q)
      ST_GUARD: if (ph_zero) st_d = ST_IDLE;
      ST_IDLE: if (req_valid) begin
        take    = 1'b1;
        st_d    = ST_SETUP;
        ph_load = 1'b1;
        ph_val  = PW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (ph_zero) begin
        st_d    = ST_PULSE;
        ph_load = 1'b1;
        ph_val  = PW'(PULSE_CYC - 1);
      end
      ST_PULSE: if (ph_zero) begin
        st_d    = ST_HOLD;
        ph_load = 1'b1;
        ph_val  = PW'(HOLD_CYC - 1);
        arm     = last_q;
      end
      ST_HOLD: if (ph_zero) begin
        st_d    = ST_GAP;
        ph_load = 1'b1;
        ph_val  = PW'(GAP_CYC - 1);
      end
      ST_GAP: if (ph_zero) begin
        if (!last_q) st_d = ST_IDLE;
        else if (poll_q) begin
          st_d    = ST_REC;
          ph_load = 1'b1;
          ph_val  = PW'(REC_CYC - 1);
        end else st_d = ST_RESP;
      end
      ST_REC: if (ph_zero) begin
        st_d    = ST_READ;
        ph_load = 1'b1;
        ph_val  = PW'(READ_CYC - 1);
      end
      ST_READ: if (ph_zero) begin
        smp  = 1'b1;
        st_d = ST_RHIGH;
      end
      ST_RHIGH: begin
        if (fin) st_d = ST_RESP;
        else begin
          st_d    = ST_READ;
          ph_load = 1'b1;
          ph_val  = PW'(READ_CYC - 1);
        end
      end
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_GUARD;
      addr_q <= '0;
      data_q <= '0;
      last_q <= 1'b0;
      poll_q <= 1'b0;
      we_n_q <= 1'b1;
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      dqoe_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
        last_q <= req_last;
        poll_q <= req_poll && req_last;
      end
      we_n_q <= (st_d != ST_PULSE);
      ce_n_q <= !(st_d inside {ST_SETUP, ST_PULSE, ST_HOLD, ST_READ});
      oe_n_q <= (st_d != ST_READ);
      dqoe_q <= (st_d inside {ST_PULSE, ST_HOLD});
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign rsp_valid   = (st_q == ST_RESP);
  assign rsp_polled  = poll_q;
  assign rsp_timeout = poll_q && fin_to;
  assign rsp_error   = poll_q && fin_err;
  assign fl_addr     = addr_q;
  assign fl_dq_out   = data_q;
  assign fl_dq_oe    = dqoe_q;
  assign fl_ce_n     = ce_n_q;
  assign fl_we_n     = we_n_q;
  assign fl_oe_n     = oe_n_q;

  // R2
  we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n);

  // R2
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  // R4
  bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe |-> fl_oe_n);

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_timeout)
                                   && $stable(rsp_error) && $stable(rsp_polled)));

  // R13
  rsp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

// File: tb/sim_flash_wr_seq.sv
`timescale 1ns/1ps
module sim_flash_wr_seq;

  localparam int AW = 22, DW = 16;
  localparam int GUARD = 6, SETUP = 2, PULSE = 3, HOLD = 1, GAP = 2;
  localparam int REC = 2, READ = 3, BLANK = 9, MAXP = 5;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready, req_last = 1'b0, req_poll = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          rsp_valid, rsp_ready = 1'b0, rsp_polled, rsp_timeout, rsp_error;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out, fl_dq_in = '0;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  always #2 clk = ~clk;

  flash_wr_seq #(.AW(AW), .DW(DW), .GUARD_CYC(GUARD), .SETUP_CYC(SETUP),
    .PULSE_CYC(PULSE), .HOLD_CYC(HOLD), .GAP_CYC(GAP), .REC_CYC(REC),
    .READ_CYC(READ), .BLANK_CYC(BLANK), .MAX_POLLS(MAXP)) u0 (.*);

  int checks = 0, fails = 0;
  logic [15:0] scr [0:7];
  logic [AW-1:0] wa [0:127];
  logic [DW-1:0] wd [0:127];
  int wcount = 0, rd_idx = 0, r4_viol = 0;
  logic [AW-1:0] last_addr = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // bus monitor and flash status model
  logic prev_we = 1'b1, prev_oe = 1'b1, first_we = 1'b1, stab_ok = 1'b1;
  int lo_run = 0, hi_run = 0, ce_run = 0, oe_run = 0, rd_base = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_data = '0;

  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n && prev_we) begin
      chk(ce_run == SETUP, "R2 ce/address lead", ce_run, SETUP);
      if (first_we) chk(hi_run >= GUARD, "R1 first strobe after reset", hi_run, GUARD);
      else chk(hi_run >= HOLD+GAP+SETUP, "R3 strobe high time", hi_run, HOLD+GAP+SETUP);
      first_we = 1'b0;
      stab_ok  = 1'b1;
    end
    if (!fl_we_n && !prev_we && (fl_addr != prev_addr || fl_dq_out != prev_data || fl_ce_n))
      stab_ok = 1'b0;
    if (fl_we_n && !prev_we) begin
      chk(lo_run == PULSE, "R2 pulse width", lo_run, PULSE);
      chk(stab_ok && fl_dq_oe && !fl_ce_n && fl_addr == prev_addr && fl_dq_out == prev_data,
          "R3 hold window", {fl_dq_oe, fl_ce_n, stab_ok}, 3'b101);
      wa[wcount] = fl_addr;
      wd[wcount] = fl_dq_out;
      wcount++;
    end
    if (fl_dq_oe && (!fl_oe_n || (fl_we_n && hi_run >= HOLD))) r4_viol++;
    if (!fl_oe_n && prev_oe) begin
      rd_idx++;
      if (rd_idx - rd_base == 1)
        chk(hi_run == HOLD+GAP+REC, "R7 recovery before read", hi_run, HOLD+GAP+REC);
      chk(fl_addr == last_addr && !fl_ce_n && !fl_dq_oe, "R8 read address", fl_addr, last_addr);
      fl_dq_in = scr[(rd_idx - rd_base - 1 > 7) ? 7 : rd_idx - rd_base - 1];
    end
    if (fl_oe_n && !prev_oe) chk(oe_run == READ, "R8 read width", oe_run, READ);
    lo_run = fl_we_n ? 0 : lo_run + 1;
    hi_run = fl_we_n ? hi_run + 1 : 0;
    ce_run = fl_ce_n ? 0 : ce_run + 1;
    oe_run = fl_oe_n ? 0 : oe_run + 1;
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
    prev_addr = fl_addr;
    prev_data = fl_dq_out;
  end

  task automatic load_script(input int s);
    for (int i = 0; i < 8; i++) scr[i] = 16'h0000;
    case (s)
      0: begin scr[0] = 16'h80; scr[1] = 16'h80; scr[2] = 16'h80; end
      1: begin scr[2] = 16'h80; scr[4] = 16'h80; scr[5] = 16'h80; end
      2: ;
      3: begin scr[0] = 16'h80; scr[1] = 16'h80; scr[2] = 16'hA0; end
      4: begin scr[1] = 16'h80; scr[2] = 16'h82; end
      5: begin scr[1] = 16'h80; scr[2] = 16'h90; end
      6: begin scr[0] = 16'h80; scr[1] = 16'h80; scr[2] = 16'hC5; end
      default: begin scr[0] = 16'h80; scr[1] = 16'h08; scr[2] = 16'h80; scr[3] = 16'h88; end
    endcase
  endtask

  // expected poll outcome from the requirements
  task automatic model(input bit poll, output int reads, output bit to, output bit er);
    int acc = 0, t;
    bit run = 1'b0;
    reads = 0; to = 1'b0; er = 1'b0;
    if (!poll) return;
    for (int k = 0; k < 8; k++) begin
      reads = k + 1;
      t = HOLD + GAP + REC + READ + k * (READ + 1);
      if (t - 1 < BLANK) continue;           // R9 ignored sample
      acc++;
      er = (scr[k] & 16'h003A) != 0;          // R12
      if (scr[k][7]) begin
        if (run) return;                      // R10
        run = 1'b1;
      end else run = 1'b0;
      if (acc == MAXP) begin to = 1'b1; return; end   // R11
    end
  endtask

  task automatic run_cmd(input int cmd, input int n, input bit poll, input int s);
    int wb, rb, r4b, er_reads;
    bit e_to, e_er;
    load_script(s);
    wb = wcount; rd_base = rd_idx; rb = rd_idx; r4b = r4_viol;
    for (int b = 0; b < n; b++) begin
      req_addr  = AW'(cmd * 256 + b * 3 + 1);
      req_data  = DW'(16'hA5A5 ^ (cmd << 4) ^ b);
      req_last  = (b == n - 1);
      req_poll  = poll;
      last_addr = req_addr;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    model(poll, er_reads, e_to, e_er);
    chk(rsp_polled == poll, poll ? "R10 polled flag" : "R6 polled flag", rsp_polled, poll);
    chk(rsp_timeout == e_to, "R11 timeout", rsp_timeout, e_to);
    chk(rsp_error == e_er, "R12 error flag", rsp_error, e_er);
    chk(rd_idx - rb == er_reads, poll ? "R9 R10 read count" : "R6 no reads",
        rd_idx - rb, er_reads);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_timeout == e_to && rsp_error == e_er,
          "R13 response held", {rsp_valid, req_ready}, 2'b10);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R13 response released", rsp_valid, 0);
    chk(wcount - wb == n, "R5 beats written", wcount - wb, n);
    for (int b = 0; b < n; b++)
      chk(wa[wb+b] == AW'(cmd * 256 + b * 3 + 1) && wd[wb+b] == DW'(16'hA5A5 ^ (cmd << 4) ^ b),
          "R5 beat order", wa[wb+b], cmd * 256 + b * 3 + 1);
    chk(r4_viol == r4b, "R4 data-bus enable window", r4_viol - r4b, 0);
  endtask

  initial begin
    int nwait, cmd;
    repeat (3) @(negedge clk);
    chk(!req_ready && fl_we_n && fl_ce_n && fl_oe_n && !fl_dq_oe && !rsp_valid,
        "R1 reset state", {req_ready, fl_we_n, fl_ce_n, fl_oe_n, fl_dq_oe, rsp_valid}, 6'b011100);
    rst_n = 1'b1;
    nwait = 0;
    while (!req_ready && nwait < 100) begin nwait++; @(negedge clk); end
    chk(nwait == GUARD, "R1 guard length", nwait, GUARD);
    cmd = 1;
    for (int n = 1; n <= 3; n++) begin
      run_cmd(cmd, n, 1'b0, 0); cmd++;
      for (int s = 0; s < 8; s++) begin run_cmd(cmd, n, 1'b1, s); cmd++; end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule